// File: doc/BRIEF.md
# Next-Fetch Line and Way Predictor

This block sits beside a two-way set-associative instruction cache and, for every fetch block of four instructions, names the cache line index and the way from which the next block should be fetched. Because the guess is available in the same cycle as the current fetch address, the cache can be steered like a direct-mapped array and taken branches cost no bubble when the guess is right. The table holds one entry per cache fetch line in each way; an entry that has never been written predicts the sequential successor line in the same way.

When the cache fills a line, the entry for that line is seeded with the following sequential line and the filled way. A slower branch predictor may rewrite any entry through a training port, for example after a taken branch or a jump through a register; it decides itself when a write is worth making. One cycle after each fetch, the block compares the index it predicted with the index the branch predictor computed. On a mismatch it raises a one-cycle override and hands the branch predictor's index back as the redirect target, unless that fetch block ends in a call or jump, in which case the line prediction stands.

Top module: `nfp_line_predictor`

## Requirements
- R1: An entry never written since reset predicts index (fetch index + 1) modulo LINES and the same way as the fetch.
- R2: A fill of line (i, w) makes later reads of that entry return index (i + 1) modulo LINES and way w, replacing any trained value.
- R3: A training write of entry (i, w) with target (n, v) makes later reads of that entry return index n and way v.
- R4: When the entry being read is written in the same cycle, the prediction output shows the value being written.
- R5: Only one table write is taken per cycle; when a fill and a training write arrive together, the fill is written and the training write is dropped.
- R6: In the cycle after a fetch, override is 1 when the branch predictor reports a valid index that differs from the index predicted for that fetch and the block is not a call or jump; redirect_idx then equals the branch predictor's index.
- R7: When the branch predictor flags the block as a call or jump, override stays 0 whatever index it reports.
- R8: When the branch predictor's index equals the predicted index, override stays 0.
- R9: Override stays 0 in any cycle not preceded by a fetch, and during reset.
- R10: Index arithmetic wraps: the successor of line LINES-1 is line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | A fetch block is being read this cycle |
| fetch_idx | input | IDX_W | Line index of the current fetch block |
| fetch_way | input | 1 | Way of the current fetch block |
| pred_idx | output | IDX_W | Predicted line index of the next fetch block |
| pred_way | output | 1 | Predicted way of the next fetch block |
| fill_valid | input | 1 | A cache line is being filled |
| fill_idx | input | IDX_W | Index of the filled line |
| fill_way | input | 1 | Way of the filled line |
| train_valid | input | 1 | Training write request |
| train_idx | input | IDX_W | Index of the entry to retrain |
| train_way | input | 1 | Way of the entry to retrain |
| train_next_idx | input | IDX_W | New predicted index for that entry |
| train_next_way | input | 1 | New predicted way for that entry |
| bp_valid | input | 1 | Branch predictor result for the previous cycle's fetch |
| bp_next_idx | input | IDX_W | Next index computed by the branch predictor |
| bp_is_jump | input | 1 | The previous block ends in a call or jump |
| override | output | 1 | One-cycle bubble: take redirect_idx instead of the line prediction |
| redirect_idx | output | IDX_W | Index to fetch from when override is 1 |

## Verification
The prediction is combinational, so it is due in the same cycle as the fetch inputs, while a fill or training write becomes visible from the next cycle onward, or in the same cycle through the bypass. The override decision is due exactly one clock after the fetch it concerns, using the prediction registered at that edge and the branch predictor inputs of the following cycle. The bench drives every input just after the falling edge, samples the outputs one nanosecond later, and advances its model only at the rising edge, so each comparison lands in the cycle where its result is due.

// File: rtl/nfp_pkg.sv
// Shared helpers for the next-fetch line predictor.
// Assumes line indices fit in a signed 32-bit int.
package nfp_pkg;

    // Sequential successor of a line index, wrapping at the line count.
    function automatic int seq_succ(input int idx, input int lines);
        return (idx + 1 >= lines) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/nfp_wsel.sv
// Write selector: merges the fill port and the training port into the
// single table write port. A fill wins; a training write arriving in the
// same cycle is dropped. Assumes the caller retries training if it cares.
module nfp_wsel #(
    parameter  int LINES = 512,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_way,
    input  logic             train_valid,
    input  logic [IDX_W-1:0] train_idx,
    input  logic             train_way,
    input  logic [IDX_W-1:0] train_next_idx,
    input  logic             train_next_way,
    output logic             wr_en,
    output logic [IDX_W:0]   wr_addr,
    output logic [IDX_W-1:0] wr_nidx,
    output logic             wr_nway
);
    import nfp_pkg::*;

    // Pick the write source, fill first, and form the entry contents.
    always_comb begin
        wr_en = fill_valid | train_valid;
        if (fill_valid) begin
            wr_addr = {fill_way, fill_idx};
            wr_nidx = IDX_W'(seq_succ(int'(fill_idx), LINES));
            wr_nway = fill_way;
        end else begin
            wr_addr = {train_way, train_idx};
            wr_nidx = train_next_idx;
            wr_nway = train_next_way;
        end
    end

endmodule

// File: rtl/nfp_table.sv
// Prediction table: one entry per line per way, asynchronous read.
// Entries carry a valid bit cleared by reset; an invalid entry reads as
// the sequential successor in the same way. A write to the entry being
// read in the same cycle is forwarded to the read output.
module nfp_table #(
    parameter  int LINES   = 512,
    localparam int IDX_W   = $clog2(LINES),
    localparam int ENTRIES = 2 ** (IDX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_way,
    input  logic             wr_en,
    input  logic [IDX_W:0]   wr_addr,
    input  logic [IDX_W-1:0] wr_nidx,
    input  logic             wr_nway,
    output logic [IDX_W-1:0] rd_nidx,
    output logic             rd_nway
);
    import nfp_pkg::*;

    logic [IDX_W:0]     mem [ENTRIES];
    logic [ENTRIES-1:0] vld;
    logic [IDX_W:0]     rd_addr;

    assign rd_addr = {rd_way, rd_idx};

    // Store the written entry contents (no reset needed on data).
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= {wr_nway, wr_nidx};
    end

    // Track which entries hold a written value.
    always_ff @(posedge clk) begin
        if (!rst_n)     vld <= '0;
        else if (wr_en) vld[wr_addr] <= 1'b1;
    end

    // Read with same-cycle forwarding and a computed default.
    always_comb begin
        if (wr_en && (wr_addr == rd_addr)) begin
            rd_nidx = wr_nidx;
            rd_nway = wr_nway;
        end else if (vld[rd_addr]) begin
            rd_nidx = mem[rd_addr][IDX_W-1:0];
            rd_nway = mem[rd_addr][IDX_W];
        end else begin
            rd_nidx = IDX_W'(seq_succ(int'(rd_idx), LINES));
            rd_nway = rd_way;
        end
    end

endmodule

// File: rtl/nfp_override.sv
// Second-stage check: registers the prediction made for a fetch and, one
// cycle later, compares it with the branch predictor's index. Raises a
// single-cycle override on mismatch unless the block is a call or jump.
// Assumes bp_* inputs refer to the fetch of the previous cycle.
module nfp_override #(
    parameter  int LINES = 512,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic [IDX_W-1:0] pred_idx,
    input  logic             bp_valid,
    input  logic [IDX_W-1:0] bp_next_idx,
    input  logic             bp_is_jump,
    output logic             override,
    output logic [IDX_W-1:0] redirect_idx
);
    logic             s2_valid;
    logic [IDX_W-1:0] s2_idx;

    // Remember whether a fetch happened last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) s2_valid <= 1'b0;
        else        s2_valid <= fetch_valid;
    end

    // Remember the index predicted for that fetch.
    always_ff @(posedge clk) begin
        s2_idx <= pred_idx;
    end

    // Decide the override and pass the corrected index through.
    always_comb begin
        override     = s2_valid && bp_valid && !bp_is_jump && (bp_next_idx != s2_idx);
        redirect_idx = bp_next_idx;
    end

endmodule

// File: rtl/nfp_line_predictor.sv
// Next-fetch line and way predictor top. Produces a same-cycle guess of
// the next fetch line and way, is seeded on fills, retrained by the
// branch predictor, and signals a one-bubble override a cycle later.
// Assumes a two-way cache with LINES fetch lines per way.
module nfp_line_predictor #(
    parameter  int LINES = 512,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic [IDX_W-1:0] fetch_idx,
    input  logic             fetch_way,
    output logic [IDX_W-1:0] pred_idx,
    output logic             pred_way,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_way,
    input  logic             train_valid,
    input  logic [IDX_W-1:0] train_idx,
    input  logic             train_way,
    input  logic [IDX_W-1:0] train_next_idx,
    input  logic             train_next_way,
    input  logic             bp_valid,
    input  logic [IDX_W-1:0] bp_next_idx,
    input  logic             bp_is_jump,
    output logic             override,
    output logic [IDX_W-1:0] redirect_idx
);
    logic             wr_en;
    logic [IDX_W:0]   wr_addr;
    logic [IDX_W-1:0] wr_nidx;
    logic             wr_nway;

    nfp_wsel #(.LINES(LINES)) u_wsel (
        .fill_valid     (fill_valid),
        .fill_idx       (fill_idx),
        .fill_way       (fill_way),
        .train_valid    (train_valid),
        .train_idx      (train_idx),
        .train_way      (train_way),
        .train_next_idx (train_next_idx),
        .train_next_way (train_next_way),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_nidx        (wr_nidx),
        .wr_nway        (wr_nway)
    );

    nfp_table #(.LINES(LINES)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (fetch_idx),
        .rd_way  (fetch_way),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_nidx (wr_nidx),
        .wr_nway (wr_nway),
        .rd_nidx (pred_idx),
        .rd_nway (pred_way)
    );

    nfp_override #(.LINES(LINES)) u_ovr (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_valid  (fetch_valid),
        .pred_idx     (pred_idx),
        .bp_valid     (bp_valid),
        .bp_next_idx  (bp_next_idx),
        .bp_is_jump   (bp_is_jump),
        .override     (override),
        .redirect_idx (redirect_idx)
    );

endmodule

// File: rtl/nfp_line_predictor_chk.sv
// Property checker for the next-fetch line predictor, bound to the top.
// Observes ports only.
module nfp_line_predictor_chk #(
    parameter  int LINES = 512,
    localparam int IDX_W = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_valid,
    input logic [IDX_W-1:0] fetch_idx,
    input logic             fetch_way,
    input logic [IDX_W-1:0] pred_idx,
    input logic             pred_way,
    input logic             fill_valid,
    input logic [IDX_W-1:0] fill_idx,
    input logic             fill_way,
    input logic             train_valid,
    input logic [IDX_W-1:0] train_idx,
    input logic             train_way,
    input logic [IDX_W-1:0] train_next_idx,
    input logic             train_next_way,
    input logic             bp_valid,
    input logic [IDX_W-1:0] bp_next_idx,
    input logic             bp_is_jump,
    input logic             override
);
    import nfp_pkg::*;

    // R2: a filled entry read on the next cycle holds the sequential successor.
    a_r2_fill_seed: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fill_valid) && fetch_valid && !fill_valid && !train_valid &&
         fetch_idx == $past(fill_idx) && fetch_way == $past(fill_way))
        |-> (pred_idx == IDX_W'(seq_succ(int'($past(fill_idx)), LINES)) &&
             pred_way == $past(fill_way)));

    // R4: a training write to the entry being read is forwarded.
    a_r4_bypass_train: assert property (@(posedge clk) disable iff (!rst_n)
        (train_valid && !fill_valid && fetch_valid &&
         train_idx == fetch_idx && train_way == fetch_way)
        |-> (pred_idx == train_next_idx && pred_way == train_next_way));

    // R5: a fill and a training write to one entry leave the fill's value.
    a_r5_fill_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fill_valid && train_valid && fill_idx == train_idx && fill_way == train_way) &&
         fetch_valid && !fill_valid && !train_valid &&
         fetch_idx == $past(fill_idx) && fetch_way == $past(fill_way))
        |-> (pred_idx == IDX_W'(seq_succ(int'($past(fill_idx)), LINES))));

    // R6 and R9: an override needs a prior fetch and a real non-jump mismatch.
    a_r6_override_cause: assert property (@(posedge clk) disable iff (!rst_n)
        override |-> (bp_valid && !bp_is_jump && $past(fetch_valid) &&
                      bp_next_idx != $past(pred_idx)));

    // R7: calls and jumps keep the line prediction.
    a_r7_jump_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_valid && bp_is_jump) |-> !override);

    // R8: agreement never overrides.
    a_r8_match_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_valid && bp_next_idx == $past(pred_idx)) |-> !override);

endmodule

bind nfp_line_predictor nfp_line_predictor_chk #(.LINES(LINES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_valid    (fetch_valid),
    .fetch_idx      (fetch_idx),
    .fetch_way      (fetch_way),
    .pred_idx       (pred_idx),
    .pred_way       (pred_way),
    .fill_valid     (fill_valid),
    .fill_idx       (fill_idx),
    .fill_way       (fill_way),
    .train_valid    (train_valid),
    .train_idx      (train_idx),
    .train_way      (train_way),
    .train_next_idx (train_next_idx),
    .train_next_way (train_next_way),
    .bp_valid       (bp_valid),
    .bp_next_idx    (bp_next_idx),
    .bp_is_jump     (bp_is_jump),
    .override       (override)
);

// File: tb/tb_nfp_line_predictor.sv
// Bench for the next-fetch line predictor: behavioural reference model
// (associative arrays) compared against the outputs every cycle.
module tb_nfp_line_predictor;
    localparam int LINES = 512;
    localparam int IW    = $clog2(LINES);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fetch_valid, fetch_way, fill_valid, fill_way;
    logic          train_valid, train_way, train_next_way;
    logic          bp_valid, bp_is_jump;
    logic [IW-1:0] fetch_idx, fill_idx, train_idx, train_next_idx, bp_next_idx;
    logic [IW-1:0] pred_idx, redirect_idx;
    logic          pred_way, override;

    always #10 clk = ~clk;

    nfp_line_predictor #(.LINES(LINES)) dut (.*);

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    int mi[int];
    int mw[int];
    bit prev_fv = 0;
    int prev_pi = 0;

    function automatic int succ(int i);
        return (i + 1) % LINES;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic clr();
        fetch_valid = 0; fetch_idx = '0; fetch_way = 0;
        fill_valid = 0;  fill_idx = '0;  fill_way = 0;
        train_valid = 0; train_idx = '0; train_way = 0;
        train_next_idx = '0; train_next_way = 0;
        bp_valid = 0; bp_next_idx = '0; bp_is_jump = 0;
    endtask

    task automatic fetch(int i, int w);
        fetch_valid = 1; fetch_idx = IW'(i); fetch_way = w[0];
    endtask
    task automatic fill(int i, int w);
        fill_valid = 1; fill_idx = IW'(i); fill_way = w[0];
    endtask
    task automatic train(int i, int w, int ni, int nw);
        train_valid = 1; train_idx = IW'(i); train_way = w[0];
        train_next_idx = IW'(ni); train_next_way = nw[0];
    endtask
    task automatic bp(int i, bit j);
        bp_valid = 1; bp_next_idx = IW'(i); bp_is_jump = j;
    endtask

    // One cycle: check outputs against the model, then advance the model.
    task automatic cyc(string tag);
        bit we = 0; int wk = 0; int wi = 0; int ww = 0;
        int k = 0; int ei = 0; int ew = 0; bit eo;
        #1;
        if (fill_valid) begin
            we = 1; wk = int'(fill_way) * LINES + int'(fill_idx);
            wi = succ(int'(fill_idx)); ww = int'(fill_way);
        end else if (train_valid) begin
            we = 1; wk = int'(train_way) * LINES + int'(train_idx);
            wi = int'(train_next_idx); ww = int'(train_next_way);
        end
        if (fetch_valid) begin
            k = int'(fetch_way) * LINES + int'(fetch_idx);
            if (we && wk == k)       begin ei = wi; ew = ww; end
            else if (mi.exists(k))   begin ei = mi[k]; ew = mw[k]; end
            else                     begin ei = succ(int'(fetch_idx)); ew = int'(fetch_way); end
            chk(tag, "pred_idx", int'(pred_idx), ei);
            chk(tag, "pred_way", int'(pred_way), ew);
        end
        eo = prev_fv && bp_valid && !bp_is_jump && (int'(bp_next_idx) != prev_pi);
        chk(tag, "override", int'(override), int'(eo));
        if (eo) chk(tag, "redirect_idx", int'(redirect_idx), int'(bp_next_idx));
        @(posedge clk);
        if (we) begin mi[wk] = wi; mw[wk] = ww; end
        prev_fv = fetch_valid;
        prev_pi = ei;
        @(negedge clk);
        clr();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        clr();
        rst_n = 0;
        repeat (3) @(negedge clk);
        fetch(3, 0); bp(99, 0);
        #1 chk("R9", "override in reset", int'(override), 0);
        @(negedge clk);
        clr();
        rst_n = 1;

        // R1 default successor and R9 no override without prior fetch.
        fetch(5, 0); bp(77, 0); cyc("R1");
        fetch(200, 1); cyc("R1");
        // R10 wrap at the last line.
        fetch(LINES - 1, 1); cyc("R10");
        fill(LINES - 1, 0); cyc("R10");
        fetch(LINES - 1, 0); cyc("R10");
        // R3 training, then R2 fill reseeds it.
        train(20, 1, 100, 0); cyc("R3");
        fetch(20, 1); cyc("R3");
        fill(20, 1); cyc("R2");
        fetch(20, 1); cyc("R2");
        // R4 same-cycle forwarding of training and fill writes.
        fetch(30, 0); train(30, 0, 7, 1); cyc("R4");
        fetch(31, 1); train(31, 1, 8, 0); cyc("R4");
        fill(31, 1); fetch(31, 1); cyc("R4");
        // R5 fill beats a simultaneous training write.
        fill(40, 0); train(40, 0, 9, 1); cyc("R5");
        fetch(40, 0); cyc("R5");
        fill(41, 0); train(50, 1, 3, 0); cyc("R5");
        fetch(50, 1); cyc("R5");
        // R6 mismatch override, R8 match stays quiet, R7 jump keeps prediction.
        fetch(60, 0); cyc("R6");
        bp(200, 0); fetch(200, 0); cyc("R6");
        bp(201, 0); cyc("R8");
        fetch(70, 1); cyc("R7");
        bp(5, 1); train(70, 1, 5, 1); cyc("R7");
        fetch(70, 1); cyc("R3");
        bp(6, 0); cyc("R6");
        // R9 branch result with no fetch in the previous cycle.
        bp(123, 0); cyc("R9");
        // Mixed stream.
        for (int n = 0; n < 60; n++) begin
            fetch((n * 37) % LINES, n % 2);
            if (n % 3 != 0) bp((n * 13) % LINES, (n % 5) == 0);
            if (n % 4 == 0) train((n * 37 + 74) % LINES, (n / 2) % 2, (n * 11) % LINES, n % 3 == 1);
            if (n % 7 == 0) fill((n * 37 + 37) % LINES, (n + 1) % 2);
            cyc("R6");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule